// File: doc/BRIEF.md
# Pseudo-Ternary Frame Line Encoder

This block turns a stream of basic-rate subscriber-loop frame bits into a three-level line signal on two wires. One wire carries a positive pulse and the other a negative pulse. When neither is high, the line has no pulse. A binary one is sent as no pulse, and a binary zero is sent as a pulse. Ordinary pulses alternate in polarity. The block departs from that rule on purpose in two places, so that a receiver can find frame boundaries:

- The frame bit repeats the polarity of the previous pulse.
- The first pulse after the first balance bit of the frame also repeats the previous polarity.

The block also works out every balance bit itself from the running parity of pulses.

The upstream framer presents one bit per strobe (192 kbit/s) with a type code and a data value. It also drives a direction select, which chooses the network-to-terminal or terminal-to-network reach for the second violation. Each encoded symbol appears on the outputs after the strobe and is held until the next strobe. A one-bit-period fault pulse reports a frame in which the second violation did not arrive within the allowed reach.

Top module: `ptern_line_encoder`

## Requirements
- R1: After reset both line outputs and the fault output are low. Every bit presented before the first frame bit produces no pulse. The first frame bit after reset is sent as a positive pulse.
- R2: For data bits (type codes 2 to 15), a value of 1 gives no pulse. A value of 0 gives a pulse whose polarity is the opposite of the previous pulse, unless R5 applies.
- R3: A bit with type code 0 (frame bit) is always a pulse, whatever its data value. Its polarity equals that of the previous pulse, which makes it a code violation.
- R4: A bit with type code 1 (balance bit) ignores its data value. It is a pulse when an odd number of pulses were sent since the previous balance bit, and no pulse when that number is even. The frame-bit pulse counts as the first pulse after a frame bit. A balance-bit pulse alternates in polarity normally.
- R5: After the first balance bit that follows a frame bit, the next pulse of any kind repeats the previous polarity. Every pulse after it alternates normally until the next frame bit.
- R6: With direction 0 (network to terminal), the fault output goes high for one bit period if the bit at position 14 after the frame bit (the frame bit is position 0) is sent while the R5 violation is still pending. With direction 1 (terminal to network) the same check applies at position 13.
- R7: The outputs change only in the clock cycle after a strobe, and they hold their values between strobes. The two line outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe: the current bit is taken |
| bit_kind | input | 4 | Bit type code (0 frame, 1 balance, 2 and up data kinds) |
| bit_val | input | 1 | Binary value of a data bit |
| dir_te | input | 1 | 0: network-to-terminal reach, 1: terminal-to-network reach |
| line_pos | output | 1 | Positive pulse for the current symbol |
| line_neg | output | 1 | Negative pulse for the current symbol |
| align_fault | output | 1 | Second violation missing at the reach limit |

## Verification
Frames with an all-ones first B channel exercise the case where the zero in the auxiliary framing bit must carry the second violation. If the pending-violation flag were armed at the wrong balance bit, that zero would alternate instead of repeating the previous polarity. Balance bits are driven with data values that contradict their expected symbol. A design that forwarded the data value, or failed to count the frame pulse in the parity, would emit the wrong pulse or space there. Frames are also left without any zero up to bit 14 (direction 0) and up to bit 13 (direction 1). These runs catch a reach limit that is off by one or swapped between the two directions. A reset in mid-stream checks that pre-frame zeros stay silent and that the first frame restarts at positive polarity.

// File: rtl/ptern_pkg.sv
package ptern_pkg;
    localparam int KIND_W = 4;

    // Type codes of the bits handed in by the framer
    typedef enum logic [KIND_W-1:0] {
        BK_FRAME = 4'd0,
        BK_BAL   = 4'd1,
        BK_B1    = 4'd2,
        BK_B2    = 4'd3,
        BK_DCH   = 4'd4,
        BK_ECHO  = 4'd5,
        BK_ACT   = 4'd6,
        BK_AUXF  = 4'd7,
        BK_NBIT  = 4'd8,
        BK_MFR   = 4'd9,
        BK_SCH   = 4'd10
    } bit_kind_e;
endpackage

// File: rtl/ptern_parity.sv
module ptern_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic is_frame,
    input  logic is_bal,
    input  logic is_mark,
    output logic odd_o
);
    typedef struct packed {
        logic odd;
    } par_state_t;

    par_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            if (is_frame)
                st_d.odd = 1'b1;        // frame pulse opens the count
            else if (is_bal)
                st_d.odd = 1'b0;        // balance bit closes the group
            else if (is_mark)
                st_d.odd = ~st_q.odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign odd_o = st_q.odd;
endmodule

// File: rtl/ptern_align.sv
module ptern_align #(
    parameter int NT_REACH = 14,
    parameter int TE_REACH = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic is_frame,
    input  logic is_bal,
    input  logic is_mark,
    input  logic dir_te,
    output logic active_o,
    output logic pending_o,
    output logic fault_o
);
    localparam int MAX_REACH = (NT_REACH > TE_REACH) ? NT_REACH : TE_REACH;
    localparam int IDX_W     = $clog2(MAX_REACH + 2);
    localparam logic [IDX_W-1:0] IDX_TOP = '1;
    localparam logic [IDX_W-1:0] NT_LIM  = IDX_W'(NT_REACH);
    localparam logic [IDX_W-1:0] TE_LIM  = IDX_W'(TE_REACH);

    typedef struct packed {
        logic             active;
        logic             await_bal;
        logic             pending;
        logic             fault;
        logic [IDX_W-1:0] idx;
    } aln_state_t;

    aln_state_t       st_d, st_q;
    logic [IDX_W-1:0] limit;

    assign limit = dir_te ? TE_LIM : NT_LIM;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.fault = 1'b0;
            if (is_frame) begin
                st_d.active    = 1'b1;
                st_d.await_bal = 1'b1;
                st_d.pending   = 1'b0;
                st_d.idx       = '0;
            end else if (st_q.active) begin
                if (st_q.idx != IDX_TOP)
                    st_d.idx = st_q.idx + 1'b1;
                if (st_q.await_bal && is_bal) begin
                    st_d.await_bal = 1'b0;
                    st_d.pending   = 1'b1;
                end else if (st_q.pending && is_mark) begin
                    st_d.pending = 1'b0;
                end
                if (st_q.pending && !is_mark && st_d.idx == limit)
                    st_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o  = st_q.active;
    assign pending_o = st_q.pending;
    assign fault_o   = st_q.fault;
endmodule

// File: rtl/ptern_polarity.sv
module ptern_polarity #(
    parameter logic START_POS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic is_mark,
    input  logic violate,
    output logic pos_o,
    output logic neg_o
);
    typedef struct packed {
        logic last_pos;
        logic pos;
        logic neg;
    } pol_state_t;

    pol_state_t st_d, st_q;
    logic       pol;

    always_comb begin
        st_d = st_q;
        pol  = violate ? st_q.last_pos : ~st_q.last_pos;
        if (strobe) begin
            if (is_mark) begin
                st_d.pos      = pol;
                st_d.neg      = ~pol;
                st_d.last_pos = pol;
            end else begin
                st_d.pos = 1'b0;
                st_d.neg = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{last_pos: START_POS, pos: 1'b0, neg: 1'b0};
        else        st_q <= st_d;
    end

    assign pos_o = st_q.pos;
    assign neg_o = st_q.neg;
endmodule

// File: rtl/ptern_line_encoder.sv
module ptern_line_encoder
    import ptern_pkg::*;
#(
    parameter int NT_REACH = 14,
    parameter int TE_REACH = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [KIND_W-1:0] bit_kind,
    input  logic              bit_val,
    input  logic              dir_te,
    output logic              line_pos,
    output logic              line_neg,
    output logic              align_fault
);
    logic is_frame, is_bal, is_mark, violate;
    logic odd, active, pending;

    assign is_frame = (bit_kind == BK_FRAME);
    assign is_bal   = (bit_kind == BK_BAL);
    // Symbols before the first frame bit are suppressed
    assign is_mark  = (active | is_frame) & (is_frame | (is_bal ? odd : ~bit_val));
    assign violate  = is_frame | pending;

    ptern_parity u_parity (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (bit_en),
        .is_frame (is_frame),
        .is_bal   (is_bal),
        .is_mark  (is_mark),
        .odd_o    (odd)
    );

    ptern_align #(
        .NT_REACH (NT_REACH),
        .TE_REACH (TE_REACH)
    ) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (bit_en),
        .is_frame  (is_frame),
        .is_bal    (is_bal),
        .is_mark   (is_mark),
        .dir_te    (dir_te),
        .active_o  (active),
        .pending_o (pending),
        .fault_o   (align_fault)
    );

    ptern_polarity #(
        .START_POS (1'b1)
    ) u_polarity (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (bit_en),
        .is_mark (is_mark),
        .violate (violate),
        .pos_o   (line_pos),
        .neg_o   (line_neg)
    );
endmodule

// File: rtl/ptern_line_encoder_chk.sv
module ptern_line_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic [3:0] bit_kind,
    input logic       bit_val,
    input logic       line_pos,
    input logic       line_neg,
    input logic       align_fault
);
    logic seen_frame_q, armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_frame_q <= 1'b0;
            armed_q      <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (bit_en && bit_kind == 4'd0) seen_frame_q <= 1'b1;
        end
    end

    assert_no_dual_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg));

    assert_hold_between_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(bit_en)) |-> ($stable(line_pos) && $stable(line_neg)));

    assert_frame_is_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_kind == 4'd0) |=> (line_pos || line_neg));

    assert_quiet_before_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !seen_frame_q && bit_kind != 4'd0) |=> (!line_pos && !line_neg));

    assert_one_is_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_kind > 4'd1 && bit_val) |=> (!line_pos && !line_neg));

    assert_fault_on_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!line_pos && !line_neg));
endmodule

bind ptern_line_encoder ptern_line_encoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .bit_kind    (bit_kind),
    .bit_val     (bit_val),
    .line_pos    (line_pos),
    .line_neg    (line_neg),
    .align_fault (align_fault)
);

// File: tb/ptern_line_encoder_test.sv
module ptern_line_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 32;

    // Row: {kind[15:12], val[11], dir[10], reps[9:5], line[4:3], fault[2], pad[1:0]}
    // line code: 0 none, 1 positive, 2 negative
    localparam logic [15:0] VEC [NVEC] = '{
        {4'd2, 1'b0, 1'b0, 5'd1,  2'd0, 1'b0, 2'b00}, // R1 zero before first frame: silent
        {4'd0, 1'b1, 1'b0, 5'd1,  2'd1, 1'b0, 2'b00}, // R1 R3 first frame positive, value ignored
        {4'd1, 1'b1, 1'b0, 5'd1,  2'd2, 1'b0, 2'b00}, // R4 odd (frame pulse) -> pulse, alternates
        {4'd2, 1'b1, 1'b0, 5'd1,  2'd0, 1'b0, 2'b00}, // R2 one -> space
        {4'd2, 1'b0, 1'b0, 5'd1,  2'd2, 1'b0, 2'b00}, // R5 first zero repeats polarity
        {4'd2, 1'b0, 1'b0, 5'd1,  2'd1, 1'b0, 2'b00}, // R2 alternates
        {4'd2, 1'b0, 1'b0, 5'd1,  2'd2, 1'b0, 2'b00}, // R2
        {4'd1, 1'b0, 1'b0, 5'd1,  2'd1, 1'b0, 2'b00}, // R4 three pulses -> pulse
        {4'd5, 1'b1, 1'b0, 5'd1,  2'd0, 1'b0, 2'b00}, // R2
        {4'd4, 1'b0, 1'b0, 5'd1,  2'd2, 1'b0, 2'b00}, // R2
        {4'd1, 1'b0, 1'b0, 5'd1,  2'd1, 1'b0, 2'b00}, // R4 one pulse -> pulse
        {4'd3, 1'b1, 1'b0, 5'd1,  2'd0, 1'b0, 2'b00}, // R2
        {4'd1, 1'b0, 1'b0, 5'd1,  2'd0, 1'b0, 2'b00}, // R4 even -> space despite value 0
        {4'd0, 1'b0, 1'b0, 5'd1,  2'd1, 1'b0, 2'b00}, // R3 repeats last positive
        {4'd1, 1'b0, 1'b0, 5'd1,  2'd2, 1'b0, 2'b00}, // R4
        {4'd2, 1'b1, 1'b0, 5'd8,  2'd0, 1'b0, 2'b00}, // R5 all-ones B1
        {4'd5, 1'b1, 1'b0, 5'd1,  2'd0, 1'b0, 2'b00},
        {4'd4, 1'b1, 1'b0, 5'd1,  2'd0, 1'b0, 2'b00},
        {4'd6, 1'b1, 1'b0, 5'd1,  2'd0, 1'b0, 2'b00},
        {4'd7, 1'b0, 1'b0, 5'd1,  2'd2, 1'b0, 2'b00}, // R5 aux framing zero violates
        {4'd8, 1'b1, 1'b0, 5'd1,  2'd0, 1'b0, 2'b00}, // R6 no fault at 14
        {4'd1, 1'b0, 1'b0, 5'd1,  2'd1, 1'b0, 2'b00}, // R4
        {4'd0, 1'b0, 1'b0, 5'd1,  2'd1, 1'b0, 2'b00}, // R3
        {4'd1, 1'b0, 1'b0, 5'd1,  2'd2, 1'b0, 2'b00}, // R4
        {4'd2, 1'b1, 1'b0, 5'd12, 2'd0, 1'b0, 2'b00}, // R6 positions 2..13, no fault
        {4'd8, 1'b1, 1'b0, 5'd1,  2'd0, 1'b1, 2'b00}, // R6 position 14 fault, dir 0
        {4'd3, 1'b0, 1'b0, 5'd1,  2'd2, 1'b0, 2'b00}, // R5 R6 late violation, fault cleared
        {4'd0, 1'b0, 1'b1, 5'd1,  2'd2, 1'b0, 2'b00}, // R3 negative frame bit
        {4'd1, 1'b0, 1'b1, 5'd1,  2'd1, 1'b0, 2'b00}, // R4
        {4'd2, 1'b1, 1'b1, 5'd11, 2'd0, 1'b0, 2'b00}, // R6 positions 2..12
        {4'd7, 1'b1, 1'b1, 5'd1,  2'd0, 1'b1, 2'b00}, // R6 position 13 fault, dir 1
        {4'd4, 1'b0, 1'b1, 5'd1,  2'd1, 1'b0, 2'b00}  // R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [3:0] bit_kind = 4'd2;
    logic       bit_val = 1'b1;
    logic       dir_te = 1'b0;
    logic       line_pos, line_neg, align_fault;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptern_line_encoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .bit_kind    (bit_kind),
        .bit_val     (bit_val),
        .dir_te      (dir_te),
        .line_pos    (line_pos),
        .line_neg    (line_neg),
        .align_fault (align_fault)
    );

    task automatic check(input string req, input logic [1:0] exp_line, input logic exp_fault);
        logic [1:0] got_line;
        got_line = {line_neg, line_pos};
        checks++;
        if (got_line !== exp_line || align_fault !== exp_fault) begin
            failures++;
            $display("FAIL %s: line=%0d fault=%0b expected line=%0d fault=%0b",
                     req, got_line, align_fault, exp_line, exp_fault);
        end
    endtask

    task automatic send(input logic [3:0] kind, input logic val, input logic dir);
        @(negedge clk);
        bit_kind = kind;
        bit_val  = val;
        dir_te   = dir;
        bit_en   = 1'b1;
        @(negedge clk);
        bit_en   = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 2'd0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            for (int r = 0; r < int'(VEC[i][9:5]); r++) begin
                send(VEC[i][15:12], VEC[i][11], VEC[i][10]);
                check($sformatf("vector %0d rep %0d", i, r), VEC[i][4:3],
                      (r == int'(VEC[i][9:5]) - 1) ? VEC[i][2] : 1'b0);
            end
        end

        // R7: no strobe, inputs changing -> outputs held
        @(negedge clk);
        bit_kind = 4'd0; bit_val = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 hold without strobe", 2'd1, 1'b0);
        bit_kind = 4'd1;
        repeat (2) @(negedge clk);
        check("R7 hold after kind change", 2'd1, 1'b0);

        // R1: reset mid-stream, restart
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset clears outputs", 2'd0, 1'b0);
        rst_n = 1'b1;
        send(4'd2, 1'b0, 1'b0);
        check("R1 pre-frame zero silent", 2'd0, 1'b0);
        send(4'd1, 1'b0, 1'b0);
        check("R1 pre-frame balance silent", 2'd0, 1'b0);
        send(4'd0, 1'b0, 1'b0);
        check("R1 first frame positive", 2'd1, 1'b0);
        send(4'd2, 1'b0, 1'b0);
        check("R2 zero before balance alternates", 2'd2, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule